// File: doc/BRIEF.md
# Double-Buffered Programmable Feedback Divider

This block divides a feedback clock by a programmable 15-bit ratio. A presettable down counter runs on the feedback clock and raises a single-cycle pulse each time it reaches zero, then reloads itself. A second output flips state on every such pulse, giving a square wave at half the pulse rate that is meant for test observation.

Ratios arrive from a control receiver as a value plus a one-cycle write strobe. A write lands in a pending stage at any time. The value is copied into an active stage only one cycle before a terminal pulse. The counter reloads from the active stage alone, so a write never shortens or stretches the period already under way.

A write can be flagged as a short frame. The receiver uses this flag when it captured only 14 ratio bits, and the top ratio bit is then forced to zero. Ratios below the legal minimum are raised to that minimum.

Top module: `fb_divider`

## Requirements
- R1: While reset is low and right after it is released, `divPulse` and `divHalf` are 0. The counter starts at 255, so the first pulse appears after the 255th rising edge following release. Every period is 256 cycles until a written ratio is transferred.
- R2: `divPulse` is high for exactly one clock cycle. The number of cycles from one pulse to the next equals the active ratio.
- R3: The ratio is the plain binary value of `ratioIn[14:0]`: bit 0 has weight 1 and bit 14 has weight 16384. For example, 0x0123 gives a period of 291.
- R4: On the rising edge where the counter holds 1, the pending ratio is copied into the active stage. This is the edge just before a pulse cycle, and the copied value sets the length of the period that starts at that pulse. A write made at any other time leaves the period in progress unchanged.
- R5: A written ratio below 17, after any short-frame masking, is stored as 17.
- R6: When `shortFrame` is 1 during a write, bit 14 of `ratioIn` is ignored and treated as 0, so the largest short-frame ratio is 16383.
- R7: `divHalf` inverts on the rising edge that ends each pulse cycle and holds its value on every other edge.
- R8: A full-frame ratio of 32767 is accepted and yields a period of 32767 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Feedback clock being divided |
| rstN | input | 1 | Active-low synchronous reset |
| ratioIn | input | 15 | Ratio value from the control receiver |
| ratioWr | input | 1 | One-cycle strobe that writes `ratioIn` into the pending stage |
| shortFrame | input | 1 | Marks a 14-bit write; the top ratio bit is cleared |
| divPulse | output | 1 | One-cycle pulse at each counter terminal event |
| divHalf | output | 1 | Square wave that inverts on every pulse |

## Verification
The bench builds the block with its default parameters: a 15-bit ratio, a minimum of 17 and a reset ratio of 256. With these values the 256-cycle period after reset and the full 32767-cycle ratio both fit in the run, together with the clamp at 17 and the short-frame mask on bit 14. Random writes land at arbitrary counter phases, including the edge where the counter holds 1. These writes exercise the rule that a ratio transfers only just before a pulse, and each pulse, its period and each half-rate toggle is compared with a cycle model built from the requirements.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  // Strobes the control sends to the datapath each cycle
  typedef struct packed {
    logic xfer;    // copy pending ratio into active stage
    logic reload;  // reload counter from active stage
  } divStrobe_t;
endpackage

// File: rtl/fbdiv_ratio_stage.sv
module fbdiv_ratio_stage #(
  parameter int RATIO_W     = 15,
  parameter int MIN_RATIO   = 17,
  parameter int RESET_RATIO = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioIn,
  input  logic               ratioWr,
  input  logic               shortFrame,
  output logic [RATIO_W-1:0] pendingRatio
);
  localparam logic [RATIO_W-1:0] MinVal   = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] ResetVal = RATIO_W'(RESET_RATIO);

  logic [RATIO_W-1:0] masked;
  logic [RATIO_W-1:0] legal;

  // Short frame carries one bit less: clear the top bit
  always_comb begin
    masked = ratioIn;
    if (shortFrame) masked[RATIO_W-1] = 1'b0;
  end

  generate
    if (MIN_RATIO > 0) begin : g_clamp
      assign legal = (masked < MinVal) ? MinVal : masked;
    end else begin : g_noclamp
      assign legal = masked;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)        pendingRatio <= ResetVal;
    else if (ratioWr) pendingRatio <= legal;
  end
endmodule

// File: rtl/fbdiv_datapath.sv
module fbdiv_datapath
  import fbdiv_pkg::*;
#(
  parameter int RATIO_W     = 15,
  parameter int RESET_RATIO = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrobe_t         strobe,
  input  logic [RATIO_W-1:0] pendingRatio,
  output logic [RATIO_W-1:0] activeRatio,
  output logic [RATIO_W-1:0] countVal,
  output logic               cntZero,
  output logic               cntOne
);
  localparam logic [RATIO_W-1:0] ResetVal = RATIO_W'(RESET_RATIO);
  localparam logic [RATIO_W-1:0] One      = RATIO_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)            activeRatio <= ResetVal;
    else if (strobe.xfer) activeRatio <= pendingRatio;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              countVal <= ResetVal - One;
    else if (strobe.reload) countVal <= activeRatio - One;
    else                    countVal <= countVal - One;
  end

  assign cntZero = (countVal == '0);
  assign cntOne  = (countVal == One);
endmodule

// File: rtl/fbdiv_control.sv
module fbdiv_control
  import fbdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntZero,
  input  logic       cntOne,
  output divStrobe_t strobe,
  output logic       divPulse,
  output logic       divHalf
);
  always_comb begin
    strobe.xfer   = cntOne;
    strobe.reload = cntZero;
  end

  assign divPulse = cntZero;

  always_ff @(posedge clk) begin
    if (!rstN)        divHalf <= 1'b0;
    else if (cntZero) divHalf <= ~divHalf;
  end
endmodule

// File: rtl/fb_divider.sv
module fb_divider
  import fbdiv_pkg::*;
#(
  parameter int RATIO_W     = 15,
  parameter int MIN_RATIO   = 17,
  parameter int RESET_RATIO = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioIn,
  input  logic               ratioWr,
  input  logic               shortFrame,
  output logic               divPulse,
  output logic               divHalf
);
  divStrobe_t         strobe;
  logic [RATIO_W-1:0] pendingRatio;
  logic [RATIO_W-1:0] activeRatio;
  logic [RATIO_W-1:0] countVal;
  logic               cntZero;
  logic               cntOne;

  fbdiv_ratio_stage #(
    .RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO), .RESET_RATIO(RESET_RATIO)
  ) u_stage (
    .clk(clk), .rstN(rstN), .ratioIn(ratioIn), .ratioWr(ratioWr),
    .shortFrame(shortFrame), .pendingRatio(pendingRatio)
  );

  fbdiv_datapath #(
    .RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pendingRatio(pendingRatio),
    .activeRatio(activeRatio), .countVal(countVal),
    .cntZero(cntZero), .cntOne(cntOne)
  );

  fbdiv_control u_ctl (
    .clk(clk), .rstN(rstN), .cntZero(cntZero), .cntOne(cntOne),
    .strobe(strobe), .divPulse(divPulse), .divHalf(divHalf)
  );
endmodule

// File: rtl/fbdiv_checker.sv
module fbdiv_checker #(
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 17
) (
  input logic               clk,
  input logic               rstN,
  input logic               ratioWr,
  input logic               shortFrame,
  input logic               divPulse,
  input logic               divHalf,
  input logic [RATIO_W-1:0] pendingRatio,
  input logic [RATIO_W-1:0] activeRatio,
  input logic [RATIO_W-1:0] countVal
);
  // R2: pulse never lasts two cycles
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);

  // R7: half-rate output flips after each pulse
  assert_half_toggle_R7: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> (divHalf != $past(divHalf)));

  // R7: half-rate output holds between pulses
  assert_half_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !divPulse |=> $stable(divHalf));

  // R5: a stored ratio is never below the minimum
  assert_clamp_R5: assert property (@(posedge clk) disable iff (!rstN)
    ratioWr |=> (pendingRatio >= RATIO_W'(MIN_RATIO)));

  // R6: a short-frame write leaves the top bit clear
  assert_short_msb_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ratioWr && shortFrame) |=> !pendingRatio[RATIO_W-1]);

  // R4: the active stage changes only after the counter held 1
  assert_xfer_timing_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeRatio) |-> ($past(countVal) == RATIO_W'(1)));
endmodule

bind fb_divider fbdiv_checker #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_chk (
  .clk(clk), .rstN(rstN), .ratioWr(ratioWr), .shortFrame(shortFrame),
  .divPulse(divPulse), .divHalf(divHalf), .pendingRatio(pendingRatio),
  .activeRatio(activeRatio), .countVal(countVal)
);

// File: tb/tb_fb_divider.sv
`timescale 1ns/1ps
module tb_fb_divider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] ratioIn = '0;
  logic        ratioWr = 1'b0;
  logic        shortFrame = 1'b0;
  logic        divPulse;
  logic        divHalf;

  int checks = 0;
  int failures = 0;
  bit modelOn = 1'b0;
  bit finished = 1'b0;

  // spec model state
  int mPend, mAct, mRem, mHalf;

  fb_divider dut (
    .clk(clk), .rstN(rstN), .ratioIn(ratioIn), .ratioWr(ratioWr),
    .shortFrame(shortFrame), .divPulse(divPulse), .divHalf(divHalf)
  );

  always #2.5 clk = ~clk;

  // R3/R5/R6: value a write should produce
  function automatic int expRatio(input logic [14:0] v, input logic sf);
    int r;
    r = sf ? int'(v[13:0]) : int'(v);
    if (r < 17) r = 17;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle model from the requirements (updated at each rising edge)
  always @(posedge clk) begin
    int oldPend, oldAct;
    if (!rstN) begin
      mPend = 256; mAct = 256; mRem = 255; mHalf = 0;
    end else begin
      oldPend = mPend; oldAct = mAct;
      if (ratioWr) mPend = expRatio(ratioIn, shortFrame);
      if (mRem == 1) mAct = oldPend;             // R4
      if (mRem == 0) begin mRem = oldAct - 1; mHalf ^= 1; end
      else mRem = mRem - 1;
    end
  end

  always @(negedge clk) begin
    if (modelOn && rstN) begin
      check(divPulse == (mRem == 0), "R2 pulse", int'(divPulse), int'(mRem == 0));
      check(divHalf == mHalf[0], "R7 half", int'(divHalf), mHalf);
    end
  end

  task automatic writeRatio(input logic [14:0] v, input logic sf);
    ratioIn = v; shortFrame = sf; ratioWr = 1'b1;
    @(negedge clk);
    ratioWr = 1'b0; shortFrame = 1'b0;
  endtask

  task automatic waitPulse();
    do @(negedge clk); while (!divPulse);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!divPulse);
  endtask

  // write just after a pulse, then measure the period following the next pulse
  task automatic directed(input logic [14:0] v, input logic sf, input string req);
    int n;
    waitPulse();
    @(negedge clk);
    writeRatio(v, sf);
    waitPulse();
    measure(n);
    check(n == expRatio(v, sf), req, n, expRatio(v, sf));
  endtask

  initial begin
    int n;
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    check(divPulse == 1'b0 && divHalf == 1'b0, "R1 in reset", int'({divPulse, divHalf}), 0);
    rstN = 1'b1;
    modelOn = 1'b1;
    // R1: first pulse after 255 edges, then period 256
    n = 0;
    do begin @(negedge clk); n++; end while (!divPulse && n < 400);
    check(n == 255, "R1 first pulse", n, 255);
    measure(n);
    check(n == 256, "R1 reset period", n, 256);

    directed(15'h0123, 1'b0, "R3 binary weights");
    directed(15'd5, 1'b0, "R5 clamp low");
    directed(15'd0, 1'b0, "R5 clamp zero");
    directed(15'd17, 1'b0, "R5 minimum");
    directed(15'h4000 | 15'd40, 1'b1, "R6 short frame msb");
    directed(15'h4000 | 15'd3, 1'b1, "R6 short frame clamp");
    directed(15'h7FFF, 1'b0, "R8 full max");
    directed(15'h7FFF, 1'b1, "R6 short max");

    // R4: mid-count write must not alter the running period
    directed(15'd100, 1'b0, "R4 setup");
    waitPulse();
    repeat (40) @(negedge clk);
    writeRatio(15'd30, 1'b0);
    measure(n);
    check(n == 100 - 41, "R4 period in progress", n, 59);
    measure(n);
    check(n == 30, "R4 new period", n, 30);

    // random writes at random phases, checked by the cycle model
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        if ($urandom_range(0, 4) == 0)
          writeRatio(15'h4000 | 15'($urandom_range(0, 60)), 1'b1);
        else
          writeRatio(15'($urandom_range(0, 80)), 1'b0);
      end else begin
        repeat ($urandom_range(1, 20)) @(negedge clk);
      end
    end
    repeat (200) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(190000 * 5);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule